// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block sits as a slave on a 64-bit memory-mapped control port and gives software access to a small 32-bit register space that is not mapped directly, such as the registers of a serial-peripheral master. Software does not address the far registers itself. It loads a data word if it wants to write, then writes one command word that holds a register word address (the byte address shifted right by two) and a write or a read request bit. The bridge runs one transaction on a simple internal register bus with a request held until an acknowledge pulse, and it clears the request bit when the transaction ends.

The request bits also serve as busy flags. Software polls the same command word it wrote until the bit it set reads back as zero. For a read it then fetches the result from the read-data word. A cycle limit can be enabled that abandons a transaction which never gets an acknowledge, drops the busy bit and raises a sticky error flag. That way a dead far side cannot hang the software poll loop.

The command word is at offset 0x10, read data is at 0x18 and write data is at 0x20. In the command word, bits [ADDR_W-1:0] are the word address, bit 8 requests a write, bit 9 requests a read and bit 10 is the error flag. With the default ADDR_W of 3, word addresses 0 to 6 reach the registers at byte addresses 0 to 24.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, offsets 0x10, 0x18 and 0x20 all read 0 and the internal request `ib_req` is low.
- R2: A host write to offset 0x20 stores bits 31:0 of the written word. Reading 0x20 returns them in bits 31:0, and bits 63:32 read 0.
- R3: A host write to 0x10 with bit 8 set starts a write. On the next cycle `ib_req`=1 and `ib_we`=1, `ib_addr` equals command bits [ADDR_W-1:0], and `ib_wdata` equals the value held at 0x20 before the command. Bit 8 of 0x10 reads 1 until the transaction ends.
- R4: A host write to 0x10 with bit 9 set, and bit 8 clear, starts a read with `ib_we`=0. On the cycle after the `ib_ack` cycle, bit 9 of 0x10 reads 0 and 0x18 bits 31:0 hold the `ib_rdata` value that was present with `ib_ack`.
- R5: While `ib_req` is high and no acknowledge or abort ends it, `ib_req`, `ib_we`, `ib_addr` and `ib_wdata` hold their values. `ib_req` falls on the cycle after an `ib_ack` cycle.
- R6: While a transaction is pending, host writes to 0x10 and to 0x20 have no effect: neither the address field, the request bits nor the write-data register changes, and no second transaction follows.
- R7: A command word with both bit 8 and bit 9 set performs only the write. The read-data register is left unchanged.
- R8: When USE_TIMEOUT is 1, a transaction that sees no `ib_ack` within TIMEOUT_CYC request cycles is abandoned. `ib_req` is high for exactly TIMEOUT_CYC cycles, then its request bit clears and bit 10 of 0x10 is set. Bit 10 stays set through later transactions until reset.
- R9: An abandoned read sets 0x18 bits 31:0 to 0 and bit 32 (the debug flag) to 1. A read that completes normally clears bit 32.
- R10: Offsets other than 0x10, 0x18 and 0x20 read 0. Host writes to 0x18 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr_en | input | 1 | Host write strobe, one cycle per write |
| h_addr | input | 8 | Host byte offset, 8-byte aligned |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data for `h_addr`, combinational |
| ib_req | output | 1 | Internal bus request, held until acknowledge or abort |
| ib_we | output | 1 | Internal bus direction, 1 for write |
| ib_addr | output | ADDR_W | Internal bus word address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_rdata | input | 32 | Internal bus read data, valid with `ib_ack` |
| ib_ack | input | 1 | Internal bus acknowledge pulse |

## Verification
The assertions check the handshake on every cycle. They confirm that a pending request keeps its address, direction and data stable and holds off any new command, that an acknowledge drops the request one cycle later, that write and read are never busy together, that no request outlives the cycle limit, and that the error flag never falls once set. The bench's scenarios are needed to show what the host sees. They cover the values captured into the read-data register, which data a write carries to the far side, the exact cycle in which the busy bit clears, and the fact that commands written while busy leave no trace. These are swept over every word address and several acknowledge latencies.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int          DW       = 32;
  localparam logic [7:0]  OFS_CMD  = 8'h10;
  localparam logic [7:0]  OFS_RDAT = 8'h18;
  localparam logic [7:0]  OFS_WDAT = 8'h20;
  localparam int          BIT_WR   = 8;
  localparam int          BIT_RD   = 9;

  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ} op_e;

  // Write wins when both request bits are set.
  function automatic op_e decode_op(input logic wr, input logic rd);
    if (wr)      return OP_WRITE;
    else if (rd) return OP_READ;
    else         return OP_NONE;
  endfunction

  function automatic logic [63:0] pack_cmd(input logic [7:0] waddr, input logic wr,
                                           input logic rd, input logic err);
    return {53'd0, err, rd, wr, waddr};
  endfunction

  function automatic logic [63:0] pack_rdat(input logic [DW-1:0] d, input logic dbg);
    return {31'd0, dbg, d};
  endfunction

  function automatic logic timeout_hit(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction
endpackage

// File: rtl/ireg_host_regs.sv
module ireg_host_regs
  import ireg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_en,
  input  logic [7:0]        h_addr,
  input  logic [63:0]       h_wdata,
  output logic [63:0]       h_rdata,
  input  logic              busy,
  input  logic              busy_wr,
  input  logic              busy_rd,
  input  logic              xfer_done,
  input  logic              xfer_abort,
  input  logic [DW-1:0]     ib_rdata,
  output op_e               start_op,
  output logic              cmd_accept,
  output logic              err_flag,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DW-1:0]     wdata_q
);
  logic [DW-1:0] rdata_q;
  logic          dbg_q;
  logic [7:0]    addr_pad;
  logic          wdat_accept;
  logic [63:0]   unused_hwdata;

  assign unused_hwdata = h_wdata;
  assign cmd_accept  = h_wr_en && (h_addr == OFS_CMD) && !busy;
  assign wdat_accept = h_wr_en && (h_addr == OFS_WDAT) && !busy;
  assign start_op    = cmd_accept ? decode_op(h_wdata[BIT_WR], h_wdata[BIT_RD]) : OP_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      dbg_q    <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (cmd_accept)  addr_q  <= h_wdata[ADDR_W-1:0];
      if (wdat_accept) wdata_q <= h_wdata[DW-1:0];
      if (busy_rd && xfer_done) begin
        rdata_q <= ib_rdata;
        dbg_q   <= 1'b0;
      end else if (busy_rd && xfer_abort) begin
        rdata_q <= '0;
        dbg_q   <= 1'b1;
      end
      if (xfer_abort) err_flag <= 1'b1;
    end
  end

  always_comb begin
    addr_pad = '0;
    addr_pad[ADDR_W-1:0] = addr_q;
  end

  always_comb begin
    case (h_addr)
      OFS_CMD:  h_rdata = pack_cmd(addr_pad, busy_wr, busy_rd, err_flag);
      OFS_RDAT: h_rdata = pack_rdat(rdata_q, dbg_q);
      OFS_WDAT: h_rdata = {32'd0, wdata_q};
      default:  h_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ireg_txn_ctrl.sv
module ireg_txn_ctrl
  import ireg_pkg::*;
#(
  parameter bit USE_TIMEOUT = 1'b1,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  op_e  start_op,
  input  logic ib_ack,
  output logic busy_wr,
  output logic busy_rd,
  output logic ib_req,
  output logic xfer_done,
  output logic xfer_abort
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic xfer_end;

  assign ib_req    = busy_wr || busy_rd;
  assign xfer_done = ib_req && ib_ack;
  assign xfer_end  = xfer_done || xfer_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_wr <= 1'b0;
      busy_rd <= 1'b0;
    end else if (xfer_end) begin
      busy_wr <= 1'b0;
      busy_rd <= 1'b0;
    end else if (!ib_req) begin
      busy_wr <= (start_op == OP_WRITE);
      busy_rd <= (start_op == OP_READ);
    end
  end

  generate
    if (USE_TIMEOUT) begin : g_timeout
      logic [CW-1:0] wait_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                wait_cnt <= '0;
        else if (!ib_req || ib_ack) wait_cnt <= '0;
        else                        wait_cnt <= wait_cnt + 1'b1;
      end
      assign xfer_abort = ib_req && !ib_ack &&
                          timeout_hit(int'(wait_cnt), TIMEOUT_CYC);
    end else begin : g_no_timeout
      assign xfer_abort = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import ireg_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter bit USE_TIMEOUT = 1'b1,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_en,
  input  logic [7:0]        h_addr,
  input  logic [63:0]       h_wdata,
  output logic [63:0]       h_rdata,
  output logic              ib_req,
  output logic              ib_we,
  output logic [ADDR_W-1:0] ib_addr,
  output logic [31:0]       ib_wdata,
  input  logic [31:0]       ib_rdata,
  input  logic              ib_ack
);
  op_e  start_op;
  logic busy_wr, busy_rd;
  logic xfer_done, xfer_abort;
  logic cmd_accept, err_flag;

  assign ib_we = busy_wr;

  ireg_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_wr_en    (h_wr_en),
    .h_addr     (h_addr),
    .h_wdata    (h_wdata),
    .h_rdata    (h_rdata),
    .busy       (ib_req),
    .busy_wr    (busy_wr),
    .busy_rd    (busy_rd),
    .xfer_done  (xfer_done),
    .xfer_abort (xfer_abort),
    .ib_rdata   (ib_rdata),
    .start_op   (start_op),
    .cmd_accept (cmd_accept),
    .err_flag   (err_flag),
    .addr_q     (ib_addr),
    .wdata_q    (ib_wdata)
  );

  ireg_txn_ctrl #(.USE_TIMEOUT(USE_TIMEOUT), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_op   (start_op),
    .ib_ack     (ib_ack),
    .busy_wr    (busy_wr),
    .busy_rd    (busy_rd),
    .ib_req     (ib_req),
    .xfer_done  (xfer_done),
    .xfer_abort (xfer_abort)
  );
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk #(
  parameter int ADDR_W      = 3,
  parameter bit USE_TIMEOUT = 1'b1,
  parameter int TIMEOUT_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ib_req,
  input logic              ib_ack,
  input logic              ib_we,
  input logic [ADDR_W-1:0] ib_addr,
  input logic [31:0]       ib_wdata,
  input logic              busy_wr,
  input logic              busy_rd,
  input logic              xfer_abort,
  input logic              err_flag,
  input logic              cmd_accept
);
  int unsigned req_cycles;
  logic        unused_acc;
  assign unused_acc = cmd_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                req_cycles <= 0;
    else if (ib_req && !ib_ack) req_cycles <= req_cycles + 1;
    else                        req_cycles <= 0;
  end

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_wr && busy_rd)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ack && !xfer_abort) |=> ib_req); // R5
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ack && !xfer_abort) |=> ($stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata))); // R5
  AST_BUSY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ack && !xfer_abort) |=> ($stable(busy_wr) && $stable(busy_rd))); // R6
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && ib_ack) |=> !ib_req); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R8
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> (err_flag && !ib_req)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_TIMEOUT && ib_req) |-> (req_cycles < TIMEOUT_CYC)); // R8
endmodule

bind ireg_bridge ireg_bridge_chk #(
  .ADDR_W(ADDR_W), .USE_TIMEOUT(USE_TIMEOUT), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ib_req     (ib_req),
  .ib_ack     (ib_ack),
  .ib_we      (ib_we),
  .ib_addr    (ib_addr),
  .ib_wdata   (ib_wdata),
  .busy_wr    (busy_wr),
  .busy_rd    (busy_rd),
  .xfer_abort (xfer_abort),
  .err_flag   (err_flag),
  .cmd_accept (cmd_accept)
);

// File: tb/ireg_bridge_bench.sv
`timescale 1ns/1ps
module ireg_bridge_bench;
  localparam int AW = 3;
  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr_en = 1'b0;
  logic [7:0]  h_addr = 8'h00;
  logic [63:0] h_wdata = '0;
  logic [63:0] h_rdata;
  logic        ib_req, ib_we;
  logic [AW-1:0] ib_addr;
  logic [31:0] ib_wdata;
  logic [31:0] ib_rdata = '0;
  logic        ib_ack = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic        resp_en = 1'b1;
  int          lat = 0;
  int          wait_cnt = 0;
  logic [31:0] mem [0:7];
  logic [63:0] rv;

  always #2 clk = ~clk;

  ireg_bridge #(.ADDR_W(AW), .USE_TIMEOUT(1'b1), .TIMEOUT_CYC(TO)) u_ireg_bridge (
    .clk(clk), .rst_n(rst_n), .h_wr_en(h_wr_en), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr),
    .ib_wdata(ib_wdata), .ib_rdata(ib_rdata), .ib_ack(ib_ack));

  // Far-side register model: acknowledges after lat extra cycles.
  always @(negedge clk) begin
    ib_ack <= 1'b0;
    if (resp_en && ib_req && !ib_ack) begin
      if (wait_cnt == lat) begin
        ib_ack   <= 1'b1;
        ib_rdata <= mem[ib_addr];
        if (ib_we) mem[ib_addr] <= ib_wdata;
        wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end else if (!ib_req) wait_cnt <= 0;
  end

  function automatic logic [31:0] pat(input int w, input int k);
    return (32'h9E3779B9 * (w + 1)) ^ (k << 20) ^ 32'h0000_5A5A;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] off, input logic [63:0] d);
    h_addr = off; h_wdata = d; h_wr_en = 1'b1;
    @(negedge clk);
    h_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [7:0] off, output logic [63:0] d);
    h_addr = off;
    #0.5;
    d = h_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] v;
    for (int i = 0; i < 200; i++) begin
      hread(8'h10, v);
      if (v[9:8] == 2'b00) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 32'hDEAD_0000 + i;
    do_reset();

    // R1 reset state
    hread(8'h10, rv); chk(rv == 64'd0, "R1 cmd", rv, 64'd0);
    hread(8'h18, rv); chk(rv == 64'd0, "R1 rdat", rv, 64'd0);
    hread(8'h20, rv); chk(rv == 64'd0, "R1 wdat", rv, 64'd0);
    chk(ib_req == 1'b0, "R1 req", {63'd0, ib_req}, 64'd0);

    // R2 write-data register, upper half reads zero
    hwrite(8'h20, 64'hFFFF_FFFF_1234_5678);
    hread(8'h20, rv); chk(rv == 64'h0000_0000_1234_5678, "R2 wdat", rv, 64'h1234_5678);

    // R10 unmapped offsets and read-only read-data register
    for (int o = 0; o < 6; o++) begin
      logic [7:0] off = 8'(o * 8);
      if (off != 8'h10 && off != 8'h18 && off != 8'h20) begin
        hread(off, rv); chk(rv == 64'd0, "R10 unmapped", rv, 64'd0);
      end
    end
    hwrite(8'h18, 64'h1_CAFE_F00D);
    hread(8'h18, rv); chk(rv == 64'd0, "R10 rdat write", rv, 64'd0);

    // R3 R4 R5 sweep over latencies and all word addresses 0..6 (bytes 0..24)
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int w = 0; w < 7; w++) begin
        logic [31:0] v = pat(w, l);
        hwrite(8'h20, {32'hFFFF_0000, v});
        hwrite(8'h10, 64'h100 | 64'(w));
        chk(ib_req && ib_we && ib_addr == AW'(w) && ib_wdata == v, "R3 bus",
            {ib_req, ib_we, 27'd0, 3'(ib_addr), ib_wdata}, {2'b11, 27'd0, 3'(w), v});
        hread(8'h10, rv); chk(rv[9:8] == 2'b01, "R3 busy", rv, 64'h100);
        wait_idle();
        chk(mem[w] == v, "R3 far data", {32'd0, mem[w]}, {32'd0, v});
        hwrite(8'h10, 64'h200 | 64'(w));
        chk(ib_req && !ib_we && ib_addr == AW'(w), "R4 bus",
            {ib_req, ib_we, 59'd0, 3'(ib_addr)}, {2'b10, 59'd0, 3'(w)});
        wait_idle();
        hread(8'h18, rv); chk(rv == {32'd0, v}, "R4 rdat", rv, {32'd0, v});
      end
    end

    // R4 R5 exact timing with one cycle of latency
    lat = 1;
    mem[5] = 32'h0BAD_BEEF;
    hwrite(8'h10, 64'h205);
    @(negedge clk);
    hread(8'h10, rv); chk(rv[9] == 1'b1 && ib_req, "R4 pending", rv, 64'h205);
    @(negedge clk);
    hread(8'h10, rv); chk(rv[9] == 1'b0 && !ib_req, "R5 req drop", rv, 64'h005);
    hread(8'h18, rv); chk(rv == 64'h0BAD_BEEF, "R4 capture", rv, 64'h0BAD_BEEF);

    // R6 commands and data written while busy are ignored
    lat = 6;
    mem[2] = 32'h0; mem[4] = 32'h4444_4444;
    hwrite(8'h20, 64'hAAAA_0001);
    hwrite(8'h10, 64'h102);
    hwrite(8'h10, 64'h204);
    hwrite(8'h20, 64'hBBBB_0002);
    chk(ib_addr == 3'd2 && ib_we && ib_wdata == 32'hAAAA_0001, "R6 bus held",
        {ib_addr, ib_wdata}, {3'd2, 32'hAAAA_0001});
    hread(8'h20, rv); chk(rv == 64'hAAAA_0001, "R6 wdat held", rv, 64'hAAAA_0001);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(!ib_req, "R6 no second txn", {63'd0, ib_req}, 64'd0);
    hread(8'h10, rv); chk(rv == 64'h002, "R6 cmd", rv, 64'h002);
    chk(mem[2] == 32'hAAAA_0001, "R6 far data", {32'd0, mem[2]}, 64'hAAAA_0001);
    hread(8'h18, rv); chk(rv == 64'h0BAD_BEEF, "R6 rdat kept", rv, 64'h0BAD_BEEF);

    // R7 both request bits: write only
    lat = 0;
    hwrite(8'h20, 64'h7777_0003);
    hwrite(8'h10, 64'h303);
    chk(ib_req && ib_we && ib_addr == 3'd3, "R7 write chosen", {62'd0, ib_req, ib_we}, 64'd3);
    wait_idle();
    chk(mem[3] == 32'h7777_0003, "R7 far data", {32'd0, mem[3]}, 64'h7777_0003);
    hread(8'h18, rv); chk(rv == 64'h0BAD_BEEF, "R7 rdat kept", rv, 64'h0BAD_BEEF);

    // R8 R9 timeout on a read
    resp_en = 1'b0;
    hwrite(8'h10, 64'h201);
    chk(ib_req, "R8 req start", {63'd0, ib_req}, 64'd1);
    repeat (TO - 1) @(negedge clk);
    chk(ib_req, "R8 req last cycle", {63'd0, ib_req}, 64'd1);
    @(negedge clk);
    chk(!ib_req, "R8 req abandoned", {63'd0, ib_req}, 64'd0);
    hread(8'h10, rv); chk(rv == 64'h401, "R8 err set", rv, 64'h401);
    hread(8'h18, rv); chk(rv == 64'h1_0000_0000, "R9 debug flag", rv, 64'h1_0000_0000);

    // R8 sticky through a good read; R9 good read clears debug flag
    resp_en = 1'b1; lat = 2;
    mem[6] = 32'h6666_1234;
    hwrite(8'h10, 64'h206);
    wait_idle();
    hread(8'h10, rv); chk(rv == 64'h406, "R8 err sticky", rv, 64'h406);
    hread(8'h18, rv); chk(rv == 64'h6666_1234, "R9 debug clear", rv, 64'h6666_1234);

    // R1 reset clears error and data registers
    do_reset();
    hread(8'h10, rv); chk(rv == 64'd0, "R1 err cleared", rv, 64'd0);
    hread(8'h18, rv); chk(rv == 64'd0, "R1 rdat cleared", rv, 64'd0);
    hread(8'h20, rv); chk(rv == 64'd0, "R1 wdat cleared", rv, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule